// File: doc/BRIEF.md
# Channel-Indexed Register File

This block is the configuration register bank that sits behind a byte-wide register bus, as a SPI slave front end would drive it. The bus offers an 8-bit address, 8-bit write data, a write strobe and a read strobe, and returns registered read data. Some registers are global: one shared copy for the whole device. Other registers are local: they exist once per channel. There are four data channels and two clock-output channels, a frame clock and a data clock.

A channel index register selects the copies that a bus access reaches. A write to a local register lands in every channel copy whose index bit is set, so one access can program all channels at once. A read of a local register returns exactly one copy, picked by a fixed priority among the set bits. Global registers and the index register never look at the index.

Top module: `chidx_regfile`

## Requirements
- R1: After reset every register holds its default. The index register at 0x05 holds 0x3F. The globals are 0x00 (0x18), 0x08 (0x00) and 0xFF (0x00). The locals in every channel are 0x10 (0x00), 0x14 (0x01) and 0x16 (0x0A).
- R2: The index register keeps only bits [5:0] of a write, and bits [7:6] always read back as 0.
- R3: A write to a local register updates the copy of each channel whose index bit is set and leaves the other copies unchanged. Bits 0 to 3 select data channels A to D, bit 4 selects the frame clock channel and bit 5 selects the data clock channel.
- R4: A read of a local register with several index bits set returns the copy of the first set channel in the order A, B, C, D, data clock (bit 5), frame clock (bit 4).
- R5: A read of a local register while the index bits are all 0 returns 0x00.
- R6: A global register is written and read the same way whatever the index holds, including an index of 0.
- R7: Bits a register does not implement are dropped on write and read as 0. The implemented masks are 0x00:0x7E, 0x08:0x03, 0xFF:0x01, 0x10:0xFF, 0x14:0x3F and 0x16:0x0F.
- R8: A write to any other address changes no register, and a read of such an address returns 0x00.
- R9: Read data is registered. It shows the addressed value in the cycle after the read strobe and holds until the next read strobe.
- R10: When the read and write strobes are both high in one cycle, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low, loads defaults |
| addr | input | 8 | Register address for the current access |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one access per high cycle |
| rd_en | input | 1 | Read strobe, one access per high cycle |
| rd_data | output | 8 | Registered read data |

## Verification
The bound checker keeps a shadow of the index register, built from bus writes. On every cycle it checks the index readback, the zero value of unimplemented bits and addresses, the zero result of a local read with an empty index, and that read data holds between strobes. Fan-out to a chosen set of channels, the read priority among several set bits, and the read-before-write order show only in the bench's scenarios. The bench sweeps all 64 index patterns for writes and for reads, and all 256 addresses after reset and after writes to unmapped addresses.

// File: rtl/chidx_pkg.sv
package chidx_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int N_LOC  = 3;
    localparam int N_GLB  = 3;

    localparam logic [ADDR_W-1:0] IDX_ADDR = 8'h05;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        byte_t idx;
        byte_t rdq;
    } top_state_t;

    // Local (per-channel) register table
    function automatic addr_t loc_addr(input int i);
        case (i)
            0:       return 8'h10;
            1:       return 8'h14;
            default: return 8'h16;
        endcase
    endfunction

    function automatic byte_t loc_mask(input int i);
        case (i)
            0:       return 8'hFF;
            1:       return 8'h3F;
            default: return 8'h0F;
        endcase
    endfunction

    function automatic byte_t loc_dflt(input int i);
        case (i)
            0:       return 8'h00;
            1:       return 8'h01;
            default: return 8'h0A;
        endcase
    endfunction

    // Global (shared) register table
    function automatic addr_t glb_addr(input int i);
        case (i)
            0:       return 8'h00;
            1:       return 8'h08;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic byte_t glb_mask(input int i);
        case (i)
            0:       return 8'h7E;
            1:       return 8'h03;
            default: return 8'h01;
        endcase
    endfunction

    function automatic byte_t glb_dflt(input int i);
        case (i)
            0:       return 8'h18;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic is_local(input addr_t a);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < N_LOC; i++) begin
            if (a == loc_addr(i)) hit = 1'b1;
        end
        return hit;
    endfunction

    function automatic logic is_global(input addr_t a);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < N_GLB; i++) begin
            if (a == glb_addr(i)) hit = 1'b1;
        end
        return hit;
    endfunction

    // Implemented-bit mask of a table register (0 for anything else)
    function automatic byte_t table_mask(input addr_t a);
        byte_t m;
        m = '0;
        for (int i = 0; i < N_LOC; i++) begin
            if (a == loc_addr(i)) m = loc_mask(i);
        end
        for (int i = 0; i < N_GLB; i++) begin
            if (a == glb_addr(i)) m = glb_mask(i);
        end
        return m;
    endfunction

endpackage

// File: rtl/chidx_sel.sv
// Turns the channel index into per-channel write enables and a one-hot
// read pick. Data channels take priority in ascending order, then the
// clock channels from the highest index bit downward.
module chidx_sel #(
    parameter int N_DATA = 4,
    parameter int N_CLK  = 2
) (
    input  logic [N_DATA+N_CLK-1:0] idx,
    output logic [N_DATA+N_CLK-1:0] wr_sel,
    output logic [N_DATA+N_CLK-1:0] rd_pick
);
    localparam int N_CH = N_DATA + N_CLK;

    logic found;

    assign wr_sel = idx;

    always_comb begin
        rd_pick = '0;
        found   = 1'b0;
        for (int i = 0; i < N_DATA; i++) begin
            if (idx[i] && !found) begin
                rd_pick[i] = 1'b1;
                found      = 1'b1;
            end
        end
        for (int k = N_CH - 1; k >= N_DATA; k--) begin
            if (idx[k] && !found) begin
                rd_pick[k] = 1'b1;
                found      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/chidx_chan.sv
// One channel's copy of the local registers.
module chidx_chan
    import chidx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  addr_t addr,
    input  byte_t wr_data,
    input  logic  wr_en,
    output byte_t rd_val
);
    byte_t regs_d [N_LOC];
    byte_t regs_q [N_LOC];

    always_comb begin
        for (int i = 0; i < N_LOC; i++) begin
            regs_d[i] = regs_q[i];
            if (wr_en && addr == loc_addr(i)) begin
                regs_d[i] = wr_data & loc_mask(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_LOC; i++) regs_q[i] <= loc_dflt(i);
        end else begin
            for (int i = 0; i < N_LOC; i++) regs_q[i] <= regs_d[i];
        end
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < N_LOC; i++) begin
            if (addr == loc_addr(i)) rd_val = regs_q[i];
        end
    end

endmodule

// File: rtl/chidx_glb.sv
// Shared registers; the channel index never reaches this bank.
module chidx_glb
    import chidx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  addr_t addr,
    input  byte_t wr_data,
    input  logic  wr_en,
    output byte_t rd_val
);
    byte_t regs_d [N_GLB];
    byte_t regs_q [N_GLB];

    always_comb begin
        for (int i = 0; i < N_GLB; i++) begin
            regs_d[i] = regs_q[i];
            if (wr_en && addr == glb_addr(i)) begin
                regs_d[i] = wr_data & glb_mask(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_GLB; i++) regs_q[i] <= glb_dflt(i);
        end else begin
            for (int i = 0; i < N_GLB; i++) regs_q[i] <= regs_d[i];
        end
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < N_GLB; i++) begin
            if (addr == glb_addr(i)) rd_val = regs_q[i];
        end
    end

endmodule

// File: rtl/chidx_regfile.sv
module chidx_regfile
    import chidx_pkg::*;
#(
    parameter int N_DATA = 4,
    parameter int N_CLK  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] addr,
    input  logic [7:0] wr_data,
    input  logic       wr_en,
    input  logic       rd_en,
    output logic [7:0] rd_data
);
    localparam int    N_CH     = N_DATA + N_CLK;
    localparam byte_t IDX_MASK = byte_t'((1 << N_CH) - 1);

    top_state_t state_d, state_q;

    logic [N_CH-1:0] wr_sel;
    logic [N_CH-1:0] rd_pick;
    byte_t           chan_val [N_CH];
    byte_t           glb_val;
    byte_t           loc_val;

    chidx_sel #(.N_DATA(N_DATA), .N_CLK(N_CLK)) u_sel (
        .idx     (state_q.idx[N_CH-1:0]),
        .wr_sel  (wr_sel),
        .rd_pick (rd_pick)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        chidx_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .addr    (addr),
            .wr_data (wr_data),
            .wr_en   (wr_en && wr_sel[c]),
            .rd_val  (chan_val[c])
        );
    end

    chidx_glb u_glb (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_data (wr_data),
        .wr_en   (wr_en),
        .rd_val  (glb_val)
    );

    always_comb begin
        loc_val = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (rd_pick[c]) loc_val = loc_val | chan_val[c];
        end
    end

    always_comb begin
        state_d = state_q;
        if (wr_en && addr == IDX_ADDR) begin
            state_d.idx = wr_data & IDX_MASK;
        end
        if (rd_en) begin
            if (addr == IDX_ADDR)     state_d.rdq = state_q.idx;
            else if (is_global(addr)) state_d.rdq = glb_val;
            else if (is_local(addr))  state_d.rdq = loc_val;
            else                      state_d.rdq = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.idx <= IDX_MASK;
            state_q.rdq <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data = state_q.rdq;

endmodule

// File: rtl/chidx_regfile_chk.sv
module chidx_regfile_chk
    import chidx_pkg::*;
#(
    parameter int N_CH = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] addr,
    input logic [7:0] wr_data,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] rd_data
);
    localparam byte_t SH_MASK = byte_t'((1 << N_CH) - 1);

    byte_t sh_idx;
    byte_t cur_mask;
    logic  mapped;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              sh_idx <= SH_MASK;
        else if (wr_en && addr == IDX_ADDR)      sh_idx <= wr_data & SH_MASK;
    end

    always_comb begin
        mapped   = (addr == IDX_ADDR) || is_global(addr) || is_local(addr);
        cur_mask = (addr == IDX_ADDR) ? SH_MASK : table_mask(addr);
    end

    AST_IDX_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr == IDX_ADDR |=> rd_data == $past(sh_idx)); // R2

    AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && mapped |=> (rd_data & ~$past(cur_mask)) == 8'h00); // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !mapped |=> rd_data == 8'h00); // R8

    AST_EMPTY_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && is_local(addr) && sh_idx == 8'h00 |=> rd_data == 8'h00); // R5

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R9

endmodule

bind chidx_regfile chidx_regfile_chk #(.N_CH(N_DATA + N_CLK)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_data (wr_data),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rd_data (rd_data)
);

// File: tb/chidx_regfile_test.sv
`timescale 1ns/1ps
module chidx_regfile_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Model state, built from the requirements
    logic [7:0] m_idx;
    logic [7:0] m_glb [3];
    logic [7:0] m_loc [6][3];

    localparam logic [7:0] LA [3] = '{8'h10, 8'h14, 8'h16};
    localparam logic [7:0] LM [3] = '{8'hFF, 8'h3F, 8'h0F};
    localparam logic [7:0] LD [3] = '{8'h00, 8'h01, 8'h0A};
    localparam logic [7:0] GA [3] = '{8'h00, 8'h08, 8'hFF};
    localparam logic [7:0] GM [3] = '{8'h7E, 8'h03, 8'h01};
    localparam logic [7:0] GD [3] = '{8'h18, 8'h00, 8'h00};
    localparam int         PRIO [6] = '{0, 1, 2, 3, 5, 4};

    chidx_regfile uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
        .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    function automatic int loc_of(input logic [7:0] a);
        for (int i = 0; i < 3; i++) if (LA[i] == a) return i;
        return -1;
    endfunction

    function automatic int glb_of(input logic [7:0] a);
        for (int i = 0; i < 3; i++) if (GA[i] == a) return i;
        return -1;
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        int li;
        int gi;
        li = loc_of(a);
        gi = glb_of(a);
        if (a == 8'h05) return m_idx;
        if (gi >= 0) return m_glb[gi];
        if (li >= 0) begin
            for (int p = 0; p < 6; p++) begin
                if (m_idx[PRIO[p]]) return m_loc[PRIO[p]][li];
            end
            return 8'h00;
        end
        return 8'h00;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        int li;
        int gi;
        li = loc_of(a);
        gi = glb_of(a);
        if (a == 8'h05) m_idx = d & 8'h3F;
        else if (gi >= 0) m_glb[gi] = d & GM[gi];
        else if (li >= 0) begin
            for (int c = 0; c < 6; c++) if (m_idx[c]) m_loc[c][li] = d & LM[li];
        end
    endtask

    task automatic model_reset();
        m_idx = 8'h3F;
        for (int i = 0; i < 3; i++) m_glb[i] = GD[i];
        for (int c = 0; c < 6; c++)
            for (int i = 0; i < 3; i++) m_loc[c][i] = LD[i];
    endtask

    task automatic check(input logic [7:0] got, input logic [7:0] exp,
                         input string req, input logic [7:0] a);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%02h idx=%02h actual=%02h expected=%02h",
                     req, a, m_idx, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_rd(input logic [7:0] a, input string req);
        logic [7:0] e;
        e = exp_read(a);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_data, e, req, a);
    endtask

    initial begin
        logic [7:0] held;
        logic [7:0] e;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R8: every address after reset, index 0x3F picks channel A
        for (int a = 0; a < 256; a++) bus_rd(8'(a), "R1");

        // R2: reserved index bits dropped
        bus_wr(8'h05, 8'hFF);
        bus_rd(8'h05, "R2");
        bus_wr(8'h05, 8'hC0);
        bus_rd(8'h05, "R2");

        // R3 / R7: fan-out over every index pattern, then read each copy
        for (int v = 0; v < 64; v++) begin
            bus_wr(8'h05, 8'(v));
            bus_wr(LA[v % 3], 8'((v * 37 + 11) & 8'hFF));
            for (int c = 0; c < 6; c++) begin
                bus_wr(8'h05, 8'(1 << c));
                for (int k = 0; k < 3; k++) bus_rd(LA[k], "R3");
            end
        end

        // Distinct values per channel so the priority result is visible
        for (int c = 0; c < 6; c++) begin
            bus_wr(8'h05, 8'(1 << c));
            bus_wr(8'h14, 8'(8'h20 + c));
        end

        // R4 / R5: read with every index pattern
        for (int v = 0; v < 64; v++) begin
            bus_wr(8'h05, 8'(v));
            bus_rd(8'h14, (v == 0) ? "R5" : "R4");
        end

        // R6 / R7: globals with an empty index and with a full index
        bus_wr(8'h05, 8'h00);
        for (int g = 0; g < 3; g++) begin
            bus_wr(GA[g], 8'hFF);
            bus_rd(GA[g], "R6");
        end
        bus_wr(8'h05, 8'h3F);
        for (int g = 0; g < 3; g++) begin
            bus_wr(GA[g], 8'hA5 ^ 8'(g));
            bus_rd(GA[g], "R7");
        end
        bus_wr(8'h05, 8'h00);
        for (int g = 0; g < 3; g++) bus_rd(GA[g], "R6");
        bus_wr(8'h05, 8'h3F);

        // R8: write to every unmapped address, then sweep all addresses
        for (int a = 0; a < 256; a++) begin
            if (a != 5 && loc_of(8'(a)) < 0 && glb_of(8'(a)) < 0)
                bus_wr(8'(a), 8'hFF);
        end
        for (int a = 0; a < 256; a++) bus_rd(8'(a), "R8");

        // R9: output holds through idle cycles and writes without a read
        bus_rd(8'h16, "R9");
        held = rd_data;
        repeat (4) @(negedge clk);
        check(rd_data, held, "R9", 8'h16);
        bus_wr(8'h16, 8'h03);
        check(rd_data, held, "R9", 8'h16);
        bus_rd(8'h16, "R9");

        // R10: read and write in one cycle return the old value
        bus_wr(8'h05, 8'h01);
        bus_wr(8'h10, 8'h5A);
        e = exp_read(8'h10);
        @(negedge clk);
        addr = 8'h10; wr_data = 8'hC3; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check(rd_data, e, "R10", 8'h10);
        model_write(8'h10, 8'hC3);
        bus_rd(8'h10, "R10");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule